// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block maps addresses seen on a local bus into PCI bus addresses through three programmable windows. Each window has a base word and a map word. The base word holds the local address range, the window size and an enable. The map word holds the upper PCI address bits, a cycle-type code and a low-address control. On every lookup the block tests the enabled windows and reports which window matched, the PCI address it produces and the kind of PCI cycle (memory, I/O or configuration) to request.

Windows may overlap, and the lowest-numbered matching window always wins. Software relies on this to open a configuration window. It enlarges window 0 so that it covers the range of window 1, reprograms window 1 to produce configuration cycles at a different local address, and afterwards restores window 1 and shrinks window 0 again. A lock flag in a system register protects the window words, and a fixed key value written to that register opens the lock.

Top module: `lbx_top`

## Requirements
- R1: A window matches when its enable bit (base bit 0) is set and the local address bits at and above the window span equal the base word bits at the same positions. Windows 0 and 1 take their span from the size code in base bits 6:4 as 2^(24+code) bytes, so code 0 is 16 MB, code 4 is 256 MB and code 5 is 512 MB.
- R2: When several windows match, the lowest-numbered one supplies the result, and its index appears on `xl_win`.
- R3: The PCI address takes the bits at and above the span from the map word, whose bits 15:0 stand for PCI address bits 31:16, and takes the bits below the span from the local address. In a configuration window, map bit k therefore sets PCI address bit 16+k, which carries a device select for slots above 12 (slot s uses map bit s-5).
- R4: In windows 0 and 1 the map bits 3:1 select the cycle: 101 gives configuration, 001 gives I/O, and any other code gives memory. `xl_cyc` encodes 0 = none, 1 = memory, 2 = I/O, 3 = configuration.
- R5: In windows 0 and 1, map bit 0 clear forces PCI address bits 1:0 to 00, and map bit 0 set passes local address bits 1:0 through.
- R6: Window 2 always spans 16 MB whatever its size field holds, always yields I/O cycles, and always passes local address bits 1:0 through.
- R7: When `lb_valid` is low or no enabled window matches, `xl_hit` is 0 and `xl_win`, `xl_cyc` and `xl_addr` are all 0.
- R8: After reset the lock flag is set and all window words are 0. While locked, writes to window words (selects 0 to 2 for base words, 4 to 6 for map words) are ignored.
- R9: A write to the system register (select 7) whose low 16 bits equal 0xA05F clears the lock. Any other write while locked leaves the lock set. While unlocked, a write sets the lock to bit 14 of the written data. The flag is visible on `cfg_locked`.
- R10: Lookup results appear on the outputs one clock after `lb_valid`/`lb_addr` are sampled. A register write takes effect at the clock edge that samples it, so a lookup sampled at that same edge still uses the old window words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0-2 base words, 4-6 map words, 7 system |
| wr_data | input | 32 | Write data |
| lb_valid | input | 1 | Lookup request |
| lb_addr | input | 32 | Local bus address to translate |
| xl_hit | output | 1 | A window matched |
| xl_win | output | 2 | Index of the winning window |
| xl_cyc | output | 2 | PCI cycle type |
| xl_addr | output | 32 | Translated PCI address |
| cfg_locked | output | 1 | Lock flag state |

## Verification
The bench uses the default parameters: 32-bit addresses, a 16-bit map word, a 16 MB minimum span and registered outputs. With 16 MB as the finest span, the top address byte alone decides every match. So each sweep runs all 256 values of that byte with two low-bit patterns and covers every window edge, every overlap and every gap of the programmed layout. Sweeps are repeated for the normal layout, the enlarged-window configuration layout and the restored layout. A bench model of the lock and the window words computes the expected results.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

   typedef enum logic [1:0] {
      CYC_NONE = 2'd0,
      CYC_MEM  = 2'd1,
      CYC_IO   = 2'd2,
      CYC_CFG  = 2'd3
   } cyc_e;

   localparam logic [2:0]  SEL_SYS    = 3'd7;
   localparam logic [2:0]  TY_CFG     = 3'b101;
   localparam logic [2:0]  TY_IO      = 3'b001;
   localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

   localparam int SZ_LSB = 4;
   localparam int SZ_W   = 3;

endpackage

// File: rtl/lbx_regs.sv
module lbx_regs
   import lbx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int MAP_W    = 16,
   parameter int NWIN     = 3,
   parameter int LOCK_BIT = 14
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [2:0]                    wr_sel,
   input  logic [ADDR_W-1:0]             wr_data,
   output logic [NWIN-1:0][ADDR_W-1:0]   base_q,
   output logic [NWIN-1:0][MAP_W-1:0]    map_q,
   output logic                          locked_q
);

   initial begin
      assert (NWIN >= 1 && NWIN <= 3)
         else $error("lbx_regs: NWIN must be 1..3 for the select encoding");
      assert (LOCK_BIT < 16 && LOCK_BIT >= 0)
         else $error("lbx_regs: LOCK_BIT must lie in the low 16 bits");
      assert (ADDR_W >= 16)
         else $error("lbx_regs: ADDR_W too small");
   end

   logic sys_wr;
   logic key_hit;

   assign sys_wr  = wr_en && (wr_sel == SEL_SYS);
   assign key_hit = (wr_data[15:0] == UNLOCK_KEY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q <= 1'b1;
      end else if (sys_wr) begin
         if (key_hit)
            locked_q <= 1'b0;
         else if (!locked_q)
            locked_q <= wr_data[LOCK_BIT];
      end
   end

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam logic [1:0] IDX = 2'(w);
      logic hit_base;
      logic hit_map;

      assign hit_base = wr_en && !locked_q && !wr_sel[2] && (wr_sel[1:0] == IDX);
      assign hit_map  = wr_en && !locked_q &&  wr_sel[2] && (wr_sel[1:0] == IDX);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[w] <= '0;
            map_q[w]  <= '0;
         end else begin
            if (hit_base) base_q[w] <= wr_data;
            if (hit_map)  map_q[w]  <= wr_data[MAP_W-1:0];
         end
      end
   end

endmodule

// File: rtl/lbx_window.sv
module lbx_window
   import lbx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int MAP_W    = 16,
   parameter int MIN_LOG2 = 24,
   parameter bit IS_IO    = 1'b0
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [MAP_W-1:0]  map,
   input  logic [ADDR_W-1:0] addr,
   output logic              match,
   output logic [1:0]        cyc,
   output logic [ADDR_W-1:0] pa
);

   localparam int MAP_SHIFT = ADDR_W - MAP_W;

   initial begin
      assert (MAP_W <= ADDR_W)
         else $error("lbx_window: MAP_W exceeds ADDR_W");
      assert (MIN_LOG2 >= MAP_SHIFT + 4)
         else $error("lbx_window: map control bits would reach the upper address");
      assert (MIN_LOG2 < ADDR_W)
         else $error("lbx_window: MIN_LOG2 must be below ADDR_W");
   end

   logic [ADDR_W-1:0] mask_hi;
   logic [ADDR_W-1:0] map_full;
   logic [ADDR_W-1:0] pa_raw;
   int unsigned       span;

   assign map_full = {map, {MAP_SHIFT{1'b0}}};

   always_comb begin
      if (IS_IO)
         span = MIN_LOG2;
      else
         span = MIN_LOG2 + int'(base[SZ_LSB +: SZ_W]);
      for (int b = 0; b < ADDR_W; b++)
         mask_hi[b] = (b >= span);
   end

   assign match  = base[0] && (((addr ^ base) & mask_hi) == '0);
   assign pa_raw = (map_full & mask_hi) | (addr & ~mask_hi);

   if (IS_IO) begin : g_io
      assign pa  = pa_raw;
      assign cyc = CYC_IO;
   end else begin : g_mem
      always_comb begin
         pa = pa_raw;
         if (!map[0]) pa[1:0] = 2'b00;
         case (map[3:1])
            TY_CFG:  cyc = CYC_CFG;
            TY_IO:   cyc = CYC_IO;
            default: cyc = CYC_MEM;
         endcase
      end
   end

endmodule

// File: rtl/lbx_pick.sv
module lbx_pick #(
   parameter int ADDR_W = 32,
   parameter int NWIN   = 3
) (
   input  logic [NWIN-1:0]              match,
   input  logic [NWIN-1:0][1:0]         cyc,
   input  logic [NWIN-1:0][ADDR_W-1:0]  pa,
   output logic                         hit,
   output logic [1:0]                   idx,
   output logic [1:0]                   cyc_o,
   output logic [ADDR_W-1:0]            pa_o
);

   always_comb begin
      hit   = 1'b0;
      idx   = '0;
      cyc_o = '0;
      pa_o  = '0;
      for (int i = NWIN - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit   = 1'b1;
            idx   = 2'(i);
            cyc_o = cyc[i];
            pa_o  = pa[i];
         end
      end
   end

endmodule

// File: rtl/lbx_top.sv
module lbx_top
   import lbx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int MAP_W    = 16,
   parameter int MIN_LOG2 = 24,
   parameter int LOCK_BIT = 14,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              lb_valid,
   input  logic [ADDR_W-1:0] lb_addr,
   output logic              xl_hit,
   output logic [1:0]        xl_win,
   output logic [1:0]        xl_cyc,
   output logic [ADDR_W-1:0] xl_addr,
   output logic              cfg_locked
);

   localparam int NWIN   = 3;
   localparam int IO_WIN = NWIN - 1;

   logic [NWIN-1:0][ADDR_W-1:0] base_q;
   logic [NWIN-1:0][MAP_W-1:0]  map_q;
   logic [NWIN-1:0]             win_match;
   logic [NWIN-1:0][1:0]        win_cyc;
   logic [NWIN-1:0][ADDR_W-1:0] win_pa;

   logic              pk_hit;
   logic [1:0]        pk_idx;
   logic [1:0]        pk_cyc;
   logic [ADDR_W-1:0] pk_pa;

   logic              nx_hit;
   logic [1:0]        nx_win;
   logic [1:0]        nx_cyc;
   logic [ADDR_W-1:0] nx_addr;

   lbx_regs #(
      .ADDR_W   (ADDR_W),
      .MAP_W    (MAP_W),
      .NWIN     (NWIN),
      .LOCK_BIT (LOCK_BIT)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .base_q   (base_q),
      .map_q    (map_q),
      .locked_q (cfg_locked)
   );

   for (genvar w = 0; w < NWIN; w++) begin : g_w
      lbx_window #(
         .ADDR_W   (ADDR_W),
         .MAP_W    (MAP_W),
         .MIN_LOG2 (MIN_LOG2),
         .IS_IO    (w == IO_WIN)
      ) i_win (
         .base  (base_q[w]),
         .map   (map_q[w]),
         .addr  (lb_addr),
         .match (win_match[w]),
         .cyc   (win_cyc[w]),
         .pa    (win_pa[w])
      );
   end

   lbx_pick #(
      .ADDR_W (ADDR_W),
      .NWIN   (NWIN)
   ) i_pick (
      .match (win_match),
      .cyc   (win_cyc),
      .pa    (win_pa),
      .hit   (pk_hit),
      .idx   (pk_idx),
      .cyc_o (pk_cyc),
      .pa_o  (pk_pa)
   );

   always_comb begin
      nx_hit  = lb_valid && pk_hit;
      nx_win  = nx_hit ? pk_idx : 2'd0;
      nx_cyc  = nx_hit ? pk_cyc : CYC_NONE;
      nx_addr = nx_hit ? pk_pa  : '0;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            xl_hit  <= 1'b0;
            xl_win  <= '0;
            xl_cyc  <= CYC_NONE;
            xl_addr <= '0;
         end else begin
            xl_hit  <= nx_hit;
            xl_win  <= nx_win;
            xl_cyc  <= nx_cyc;
            xl_addr <= nx_addr;
         end
      end
   end else begin : g_comb
      assign xl_hit  = nx_hit;
      assign xl_win  = nx_win;
      assign xl_cyc  = nx_cyc;
      assign xl_addr = nx_addr;
   end

endmodule

// File: rtl/lbx_checker.sv
module lbx_checker
   import lbx_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int MAP_W   = 16,
   parameter int NWIN    = 3,
   parameter bit REG_OUT = 1'b1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         wr_en,
   input logic [2:0]                   wr_sel,
   input logic [ADDR_W-1:0]            wr_data,
   input logic                         lb_valid,
   input logic                         xl_hit,
   input logic [1:0]                   xl_win,
   input logic [1:0]                   xl_cyc,
   input logic [ADDR_W-1:0]            xl_addr,
   input logic                         cfg_locked,
   input logic [NWIN-1:0][ADDR_W-1:0]  base_q,
   input logic [NWIN-1:0][MAP_W-1:0]   map_q
);

   // R8: a locked register file ignores window writes
   p_lock_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_locked && wr_en && wr_sel != SEL_SYS) |=> ($stable(base_q) && $stable(map_q)));

   // R9: the key always opens the lock
   p_unlock_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_SYS && wr_data[15:0] == UNLOCK_KEY) |=> !cfg_locked);

   // R9: non-key system writes cannot open a locked file
   p_stay_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_locked && !(wr_en && wr_sel == SEL_SYS && wr_data[15:0] == UNLOCK_KEY)) |=> cfg_locked);

   // R7: a miss drives all result fields to zero
   p_miss_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_hit |-> (xl_cyc == CYC_NONE && xl_win == 2'd0 && xl_addr == '0));

   // R4: a hit always names a real cycle and an existing window
   p_hit_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xl_hit |-> (xl_cyc != CYC_NONE && int'(xl_win) < NWIN));

   // R6: the last window only produces I/O cycles
   p_io_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_hit && int'(xl_win) == NWIN - 1) |-> xl_cyc == CYC_IO);

   // R10: a registered hit follows a sampled request
   p_hit_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_OUT && xl_hit) |-> $past(lb_valid));

endmodule

bind lbx_top lbx_checker #(
   .ADDR_W  (ADDR_W),
   .MAP_W   (MAP_W),
   .NWIN    (NWIN),
   .REG_OUT (REG_OUT)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .wr_data    (wr_data),
   .lb_valid   (lb_valid),
   .xl_hit     (xl_hit),
   .xl_win     (xl_win),
   .xl_cyc     (xl_cyc),
   .xl_addr    (xl_addr),
   .cfg_locked (cfg_locked),
   .base_q     (base_q),
   .map_q      (map_q)
);

// File: tb/test_lbx_top.sv
`timescale 1ns/1ps
module test_lbx_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        lb_valid = 1'b0;
   logic [31:0] lb_addr = '0;
   logic        xl_hit;
   logic [1:0]  xl_win;
   logic [1:0]  xl_cyc;
   logic [31:0] xl_addr;
   logic        cfg_locked;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [31:0] sb [3];
   logic [15:0] sm [3];
   logic        s_locked;

   always #2.5 clk = ~clk;

   lbx_top i_lbx_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .lb_valid   (lb_valid),
      .lb_addr    (lb_addr),
      .xl_hit     (xl_hit),
      .xl_win     (xl_win),
      .xl_cyc     (xl_cyc),
      .xl_addr    (xl_addr),
      .cfg_locked (cfg_locked)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected result from the requirements
   task automatic model(input logic v, input logic [31:0] a, output logic h,
                        output logic [1:0] w, output logic [1:0] c, output logic [31:0] p);
      h = 1'b0; w = 2'd0; c = 2'd0; p = 32'd0;
      if (v) begin
         for (int i = 2; i >= 0; i--) begin
            int sp;
            logic [31:0] m;
            logic [31:0] pp;
            logic [2:0]  ty;
            sp = (i == 2) ? 24 : 24 + int'(sb[i][6:4]);
            m  = 32'hFFFF_FFFF << sp;
            if (sb[i][0] && ((a ^ sb[i]) & m) == 32'd0) begin
               pp = ({sm[i], 16'h0} & m) | (a & ~m);
               if (i != 2 && !sm[i][0]) pp[1:0] = 2'b00;
               ty = sm[i][3:1];
               h  = 1'b1;
               w  = 2'(i);
               c  = (i == 2) ? 2'd2 : (ty == 3'b101) ? 2'd3 : (ty == 3'b001) ? 2'd2 : 2'd1;
               p  = pp;
            end
         end
      end
   endtask

   task automatic shadow_write(input logic [2:0] sel, input logic [31:0] d);
      if (sel == 3'd7) begin
         if (d[15:0] == 16'hA05F) s_locked = 1'b0;
         else if (!s_locked) s_locked = d[14];
      end else if (!s_locked && sel != 3'd3) begin
         if (sel[2]) sm[sel[1:0]] = d[15:0];
         else        sb[sel[1:0]] = d;
      end
   endtask

   task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      shadow_write(sel, d);
   endtask

   task automatic look(input string tag, input logic v, input logic [31:0] a);
      logic h; logic [1:0] w; logic [1:0] c; logic [31:0] p;
      model(v, a, h, w, c, p);
      @(negedge clk);
      lb_valid = v; lb_addr = a;
      @(negedge clk);
      chk({tag, " hit/win/cyc/addr"}, {27'd0, xl_hit, xl_win, xl_cyc, xl_addr},
          {27'd0, h, w, c, p});
   endtask

   task automatic sweep(input string tag);
      for (int hb = 0; hb < 256; hb++) begin
         look(tag, 1'b1, {8'(hb), 24'hABCDE7});
         look(tag, 1'b1, {8'(hb), 24'h012342});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) begin sb[i] = '0; sm[i] = '0; end
      s_locked = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      chk("R8 reset lock", {63'd0, cfg_locked}, 64'd1);
      chk("R7 reset outputs", {27'd0, xl_hit, xl_win, xl_cyc, xl_addr}, 64'd0);
      look("R7 all disabled", 1'b1, 32'h4000_0000);

      // R8 writes ignored while locked
      reg_write(3'd0, 32'h4000_0041);
      look("R8 locked base write", 1'b1, 32'h4000_0010);
      chk("R8 locked miss", {63'd0, xl_hit}, 64'd0);

      // R9 lock protocol
      reg_write(3'd7, 32'h0000_1234);
      chk("R9 non-key keeps lock", {63'd0, cfg_locked}, 64'd1);
      reg_write(3'd7, 32'h0000_A05F);
      chk("R9 key unlocks", {63'd0, cfg_locked}, 64'd0);

      // normal layout
      reg_write(3'd0, 32'h4000_0041);  // 256 MB, enabled
      reg_write(3'd4, 32'h0000_0006);  // memory at PCI 0
      reg_write(3'd1, 32'h5000_0041);  // 256 MB, enabled
      reg_write(3'd5, 32'h0000_1007);  // memory at PCI 0x10000000, low bits kept
      reg_write(3'd2, 32'h6000_0071);  // size field ignored
      reg_write(3'd6, 32'h0000_0000);
      sweep("R1 normal layout sweep");

      look("R3 window1 translate", 1'b1, 32'h5123_4567);
      chk("R3 window1 literal", {32'd0, xl_addr}, {32'd0, 32'h1123_4567});
      look("R6 io window", 1'b1, 32'h60AB_1233);
      chk("R6 io literal", {28'd0, xl_win, xl_cyc, xl_addr}, {28'd0, 2'd2, 2'd2, 32'h00AB_1233});
      look("R6 io 16MB edge", 1'b1, 32'h6100_0000);
      chk("R6 beyond io span misses", {63'd0, xl_hit}, 64'd0);
      look("R5 window0 low bits forced", 1'b1, 32'h4000_0013);
      chk("R5 forced literal", {32'd0, xl_addr}, {32'd0, 32'h0000_0010});

      // configuration layout: enlarge window 0, reuse window 1
      reg_write(3'd0, 32'h4000_0051);  // 512 MB
      reg_write(3'd1, 32'h6100_0001);  // 16 MB at 0x61000000
      reg_write(3'd5, 32'h0000_010A);  // config, slot 13 select (map bit 8)
      look("R2 overlap lower wins", 1'b1, 32'h5000_0100);
      chk("R2 overlap literal", {30'd0, xl_win, xl_addr}, {30'd0, 2'd0, 32'h1000_0100});
      look("R4 config cycle", 1'b1, 32'h6100_0A07);
      chk("R4 config literal", {28'd0, xl_win, xl_cyc, xl_addr}, {28'd0, 2'd1, 2'd3, 32'h0100_0A04});
      sweep("R2 config layout sweep");
      reg_write(3'd5, 32'h0000_010B);
      look("R5 low bits passed", 1'b1, 32'h6100_0A07);
      chk("R5 passed literal", {32'd0, xl_addr}, {32'd0, 32'h0100_0A07});

      // I/O code in window 0
      reg_write(3'd4, 32'h0000_0002);
      look("R4 io code window0", 1'b1, 32'h4800_0000);
      chk("R4 io literal", {62'd0, xl_cyc}, 64'd2);

      // R10 same-cycle write uses old words
      begin
         logic h; logic [1:0] w; logic [1:0] c; logic [31:0] p;
         model(1'b1, 32'h4800_0004, h, w, c, p);
         @(negedge clk);
         wr_en = 1'b1; wr_sel = 3'd4; wr_data = 32'h0000_0006;
         lb_valid = 1'b1; lb_addr = 32'h4800_0004;
         @(negedge clk);
         wr_en = 1'b0;
         chk("R10 old words used", {27'd0, xl_hit, xl_win, xl_cyc, xl_addr}, {27'd0, h, w, c, p});
         shadow_write(3'd4, 32'h0000_0006);
      end
      look("R10 new words next", 1'b1, 32'h4800_0004);
      chk("R10 new literal", {62'd0, xl_cyc}, 64'd1);

      // restore layout, shrink window 0
      reg_write(3'd1, 32'h5000_0041);
      reg_write(3'd5, 32'h0000_1007);
      reg_write(3'd0, 32'h4000_0041);
      look("R2 restored window1", 1'b1, 32'h5000_0100);
      chk("R2 restored literal", {62'd0, xl_win}, 64'd1);
      sweep("R1 restored sweep");

      // R1 disable bit
      reg_write(3'd1, 32'h5000_0040);
      look("R1 disabled window", 1'b1, 32'h5000_0100);
      chk("R1 disabled miss", {63'd0, xl_hit}, 64'd0);

      // R7 invalid request
      look("R7 no request", 1'b0, 32'h4000_0100);
      chk("R7 idle literal", {27'd0, xl_hit, xl_win, xl_cyc, xl_addr}, 64'd0);

      // R9 relock and R8 blocked write
      reg_write(3'd7, 32'h0000_4000);
      chk("R9 relock", {63'd0, cfg_locked}, 64'd1);
      reg_write(3'd0, 32'h0000_0000);
      look("R8 relocked write ignored", 1'b1, 32'h4000_0100);
      chk("R8 window0 still live", {63'd0, xl_hit}, 64'd1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule